// File: doc/BRIEF.md
# Repeated-Addition Sequential Multiplier

This block multiplies two unsigned `WIDTH`-bit numbers. It adds the multiplicand into a double-width accumulator once for every unit of the multiplier. A pulse on `start` while the block is idle captures both operand buses and clears the accumulator. The block then adds and counts down, one addition per clock, until the multiplier copy reaches zero. Because of this, the time to a result grows with the multiplier's value.

The control is a one-hot state machine with one flip-flop for each state. It drives the datapath through a small set of strobes. The product output always shows the accumulator register. The `done` output is high whenever the controller is idle. An asynchronous `rst` returns the block to idle from any state.

Top module: `rep_add_mul`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `done` is 1 and `prod` is 0. This holds even when `rst` is raised in the middle of a multiplication.
- R2: A clock edge with `start` high and `done` high captures `opA` as the multiplicand and `opB` as the multiplier. The same edge clears `prod` to 0 and lowers `done`.
- R3: When `done` returns high, `prod` equals the exact 2·WIDTH-bit product opA·opB. This includes (2^WIDTH−1)·(2^WIDTH−1).
- R4: After the capturing edge, `prod` equals opA·i on the i-th busy cycle (i counted from 0). Each busy cycle with a nonzero remaining count adds the zero-extended multiplicand exactly once.
- R5: `done` stays low for exactly opB+1 cycles after the capturing edge. A zero multiplier therefore gives one busy cycle and a product of 0.
- R6: Exactly one state flip-flop is set at all times.
- R7: While `done` is low, `start` and changes on `opA`/`opB` have no effect on the result or on the latency.
- R8: While `done` is high and `start` is low, `prod` holds its value.
- R9: `done` is high exactly when the controller is in its idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous active-high reset to idle |
| start | input | 1 | Begin a multiplication (honoured only when idle) |
| opA | input | WIDTH | Multiplicand bus |
| opB | input | WIDTH | Multiplier bus |
| prod | output | 2*WIDTH | Accumulator (product) register |
| done | output | 1 | High while idle; result valid |

## Verification
The bound checker checks these on every cycle:
- The one-hot state vector.
- Clearing of the accumulator on a captured start.
- The single addition of the held multiplicand on each counting cycle.
- That the operands stay fixed while busy.
- That the product holds while idle.

Only the bench's scenarios can show the rest:
- That the final value is the true arithmetic product for every operand pair.
- That the busy time matches the multiplier plus one.
- That a start pulse and bus changes in mid-run leave the result untouched.
- That a reset raised in mid-run recovers cleanly.

// File: rtl/rep_add_mul_pkg.sv
package rep_add_mul_pkg;
  // one-hot state bit positions
  localparam int ST_IDLE = 0;
  localparam int ST_LOOP = 1;
  localparam int NUM_ST  = 2;

  typedef struct packed {
    logic loadOps;  // capture operand buses
    logic clrProd;  // zero the accumulator
    logic addStep;  // accumulate multiplicand, count down
  } strobe_t;
endpackage

// File: rtl/rep_add_mul_ctrl.sv
module rep_add_mul_ctrl
  import rep_add_mul_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              arZero,
  output strobe_t           strobe,
  output logic              done,
  output logic [NUM_ST-1:0] state
);
  logic [NUM_ST-1:0] stateNxt;

  always_comb begin
    stateNxt          = '0;
    stateNxt[ST_IDLE] = (state[ST_IDLE] & ~start) | (state[ST_LOOP] & arZero);
    stateNxt[ST_LOOP] = (state[ST_IDLE] & start)  | (state[ST_LOOP] & ~arZero);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= NUM_ST'(1) << ST_IDLE;
    else     state <= stateNxt;
  end

  always_comb begin
    strobe.loadOps = state[ST_IDLE] & start;
    strobe.clrProd = state[ST_IDLE] & start;
    strobe.addStep = state[ST_LOOP] & ~arZero;
  end

  assign done = state[ST_IDLE];
endmodule

// File: rtl/rep_add_mul_dp.sv
module rep_add_mul_dp
  import rep_add_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            strobe,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [2*WIDTH-1:0] prod,
  output logic [WIDTH-1:0]   mcand,
  output logic               arZero
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcandQ;
  logic [WIDTH-1:0] countQ;
  logic [PW-1:0]    prodQ;
  logic [PW-1:0]    sum;

  assign sum    = prodQ + {{WIDTH{1'b0}}, mcandQ};
  assign arZero = (countQ == '0);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      mcandQ <= '0;
      countQ <= '0;
    end else if (strobe.loadOps) begin
      mcandQ <= opA;
      countQ <= opB;
    end else if (strobe.addStep) begin
      countQ <= countQ - 1'b1;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                 prodQ <= '0;
    else if (strobe.clrProd) prodQ <= '0;
    else if (strobe.addStep) prodQ <= sum;
  end

  assign prod  = prodQ;
  assign mcand = mcandQ;
endmodule

// File: rtl/rep_add_mul.sv
module rep_add_mul
  import rep_add_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [2*WIDTH-1:0] prod,
  output logic               done
);
  strobe_t           strobe;
  logic              arZero;
  logic [NUM_ST-1:0] ctrlState;
  logic [WIDTH-1:0]  mcandHeld;

  rep_add_mul_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .arZero(arZero),
    .strobe(strobe), .done(done), .state(ctrlState)
  );

  rep_add_mul_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .opA(opA), .opB(opB),
    .prod(prod), .mcand(mcandHeld), .arZero(arZero)
  );
endmodule

// File: rtl/rep_add_mul_chk.sv
module rep_add_mul_chk
  import rep_add_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [2*WIDTH-1:0] prod,
  input logic               done,
  input logic [NUM_ST-1:0]  ctrlState,
  input logic [WIDTH-1:0]   mcandHeld,
  input logic               arZero
);
  a_r6_one_hot: assert property (@(posedge clk) disable iff (rst)
    $countones(ctrlState) == 1);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done == ctrlState[ST_IDLE]);

  a_r2_load_clears: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> (prod == '0 && !done));

  a_r4_single_add: assert property (@(posedge clk) disable iff (rst)
    (!done && !arZero) |=> (prod == $past(prod) + {{WIDTH{1'b0}}, $past(mcandHeld)}));

  a_r7_operand_held: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(mcandHeld));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> $stable(prod));
endmodule

bind rep_add_mul rep_add_mul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .start(start), .prod(prod), .done(done),
  .ctrlState(ctrlState), .mcandHeld(mcandHeld), .arZero(arZero)
);

// File: tb/rep_add_mul_bench.sv
module rep_add_mul_bench;
  localparam int W   = 4;
  localparam int MAXV = (1 << W) - 1;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [W-1:0]   opA = '0;
  logic [W-1:0]   opB = '0;
  logic [2*W-1:0] prod;
  logic           done;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rep_add_mul #(.WIDTH(W)) u_rep_add_mul (
    .clk(clk), .rst(rst), .start(start), .opA(opA), .opB(opB),
    .prod(prod), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runOp(input int a, input int b, input bit disturb);
    int i;
    @(negedge clk);
    opA = W'(a); opB = W'(b); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(prod == '0, "R2 clear", int'(prod), 0);
    check(done == 1'b0, "R2 busy", int'(done), 0);
    i = 0;
    while (!done && i <= MAXV + 2) begin
      check(int'(prod) == a * i, "R4 step", int'(prod), a * i);
      if (disturb && i == 1) begin
        start = 1'b1; opA = ~W'(a); opB = ~W'(b);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      i++;
    end
    start = 1'b0;
    check(i == b + 1, disturb ? "R7 latency" : "R5 latency", i, b + 1);
    check(int'(prod) == a * b, disturb ? "R7 product" : "R3 product", int'(prod), a * b);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R1 reset done", int'(done), 1);
    check(prod == '0, "R1 reset prod", int'(prod), 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b1, "R9 idle done", int'(done), 1);
    check(prod == '0, "R1 after release", int'(prod), 0);

    // exhaustive sweep; R6 one-hot is exercised by every busy/idle check
    for (int a = 0; a <= MAXV; a++)
      for (int b = 0; b <= MAXV; b++)
        runOp(a, b, ((a + b) % 3) == 0 && b >= 1);

    runOp(MAXV, MAXV, 1'b0);
    check(int'(prod) == MAXV * MAXV, "R3 max", int'(prod), MAXV * MAXV);

    // R8: idle hold while buses move
    begin
      int held;
      held = int'(prod);
      for (int k = 0; k < 6; k++) begin
        opA = W'(k * 5); opB = W'(k * 3);
        @(negedge clk);
        check(int'(prod) == held, "R8 hold", int'(prod), held);
        check(done == 1'b1, "R6 single idle state", int'(done), 1);
      end
    end

    // R1: reset in mid-run
    opA = W'(7); opB = W'(MAXV); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R9 busy", int'(done), 0);
    rst = 1'b1;
    #1;
    check(done == 1'b1, "R1 async done", int'(done), 1);
    check(prod == '0, "R1 async prod", int'(prod), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b1, "R1 recovered", int'(done), 1);
    check(prod == '0, "R1 recovered prod", int'(prod), 0);
    runOp(3, 5, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule